// File: doc/BRIEF.md
# Write-Turnaround Idle Gap Controller

This block sits between an internal access requester and an external memory bus that is divided into several chip-select areas. Each area has a small configuration register that holds a 3-bit write-recovery code. When the bus finishes a write, the block loads a countdown from the code of that area. While the countdown is running, it holds back a read, or a further write to the same area, by keeping its ready line low. Writes to a different area are not held back.

The block also sets what the bus pins do in standby. There are two groups: the address, chip-select, strobe and byte-enable pins, and the clock, clock-enable and row/column strobe pins. One global register bit per group chooses whether that group stays driven or floats while the standby input is high. Outside standby, both groups are always driven.

Software writes and reads the configuration registers through a plain address/data/write-enable port. Addresses 0 to NUM_AREAS-1 select the area registers. Address NUM_AREAS selects the global standby register.

Top module: `bus_turnaround_gap`

## Requirements
- R1: In an area register, bits 29:27 hold the idle code. After an accepted write, a following read is stalled for 0, 1, 2 or 4 cycles for codes 000, 001, 010 and 011 respectively.
- R2: Codes 100 through 111 stall for 4 cycles, the same as 011.
- R3: An accepted read loads no stall. An access presented right after a read is accepted without delay.
- R4: After a write, the next write to the same area is stalled by that area's code. A write to a different area is accepted at once.
- R5: Reset leaves every area register reading 0x1800_0000 (idle code 011) and the global register reading 0.
- R6: Area register bits 31:30 and 26:0 always read 0, and writes to them have no effect.
- R7: While standby is high, bit 1 of the global register sets the output enable of the address, select, strobe and byte-enable group (1 = driven, 0 = floating).
- R8: While standby is high, bit 0 of the global register sets the output enable of the clock, clock-enable and row/column strobe group, independently of bit 1.
- R9: While standby is low, both pin groups are enabled regardless of the global register.
- R10: The stall length is fixed when the write is accepted. It counts down by one each cycle, and req_ready (for read or same-area write) is high exactly when it reaches zero. It uses the code of the area written last. A configuration write that lands in the same cycle, or during the count, does not change it.
- R11: In the global register only bits 1:0 are stored. Other bits read 0, and addresses above NUM_AREAS read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Register address (area index or NUM_AREAS for global) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr |
| req_valid | input | 1 | Requester has an access pending |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_area | input | AREA_W | Chip-select area of the pending access |
| req_ready | output | 1 | Access may be accepted this cycle |
| standby | input | 1 | Bus is in standby |
| mem_pins_oe | output | 1 | Output enable for address/select/strobe/byte-enable group |
| clk_pins_oe | output | 1 | Output enable for clock/clock-enable/row-column strobe group |

## Verification
The collision of interest is a configuration write to an area that lands in the same clock edge as an accepted bus write to that same area. Either the old code or the new one could seed the stall. The bench provokes this by driving cfg_we and an accepted write to the same area in one cycle, replacing code 011 with 000. It then expects the following read to wait the old four cycles, and the next write-read pair to wait none. A second overlap, a write to another area during a running count, is judged by the read that follows, which must take the new area's length.

// File: rtl/turn_pkg.sv
package turn_pkg;

    localparam int REG_W       = 32;
    localparam int CODE_W      = 3;
    localparam int CODE_LSB    = 27;
    localparam int CNT_W       = 3;
    localparam logic [CODE_W-1:0] CODE_RST = 3'b011;

    typedef logic [CODE_W-1:0] idle_code_t;
    typedef logic [CNT_W-1:0]  idle_cnt_t;

    typedef struct packed {
        logic drive_mem;   // bit 1: address/select/strobe/byte-enable group
        logic drive_clk;   // bit 0: clock/clock-enable/row-column group
    } standby_cfg_t;

    function automatic idle_cnt_t code_to_cycles(idle_code_t code);
        case (code)
            3'b000:  return idle_cnt_t'(0);
            3'b001:  return idle_cnt_t'(1);
            3'b010:  return idle_cnt_t'(2);
            default: return idle_cnt_t'(4);
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_area_reg(idle_code_t code);
        logic [REG_W-1:0] v;
        v = '0;
        v[CODE_LSB +: CODE_W] = code;
        return v;
    endfunction

endpackage

// File: rtl/turn_cfg_regs.sv
module turn_cfg_regs
    import turn_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    parameter int AREA_W    = 3,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output idle_code_t           idle_codes [NUM_AREAS],
    output standby_cfg_t         sb_cfg
);

    localparam logic [ADDR_W-1:0] GLOBAL_ADDR = ADDR_W'(NUM_AREAS);

    logic is_area;
    assign is_area = (cfg_addr < GLOBAL_ADDR);

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
        always_ff @(posedge clk) begin
            if (rst) begin
                idle_codes[a] <= CODE_RST;
            end else if (cfg_we && cfg_addr == ADDR_W'(a)) begin
                idle_codes[a] <= cfg_wdata[CODE_LSB +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sb_cfg <= '0;
        end else if (cfg_we && cfg_addr == GLOBAL_ADDR) begin
            sb_cfg <= standby_cfg_t'(cfg_wdata[1:0]);
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (is_area) begin
            cfg_rdata = pack_area_reg(idle_codes[cfg_addr[AREA_W-1:0]]);
        end else if (cfg_addr == GLOBAL_ADDR) begin
            cfg_rdata = {{(REG_W-2){1'b0}}, sb_cfg};
        end
    end

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:30] == 2'b00);

    a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        is_area |-> cfg_rdata[CODE_LSB-1:0] == '0);

    a_r5_reset_global: assert property (@(posedge clk)
        rst |=> sb_cfg == '0);

    a_r11_global_write: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == GLOBAL_ADDR) |=> sb_cfg == $past(cfg_wdata[1:0]));

endmodule

// File: rtl/turn_idle_ctrl.sv
module turn_idle_ctrl
    import turn_pkg::*;
#(
    parameter int NUM_AREAS = 8,
    parameter int AREA_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    input  idle_code_t        idle_codes [NUM_AREAS],
    output logic              req_ready
);

    idle_cnt_t         gap_cnt;
    logic [AREA_W-1:0] last_wr_area;
    logic              held;
    logic              take_write;

    assign held       = (gap_cnt != '0) && (!req_write || req_area == last_wr_area);
    assign req_ready  = !held;
    assign take_write = req_valid && req_ready && req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt      <= '0;
            last_wr_area <= '0;
        end else if (take_write) begin
            gap_cnt      <= code_to_cycles(idle_codes[req_area]);
            last_wr_area <= req_area;
        end else if (gap_cnt != '0) begin
            gap_cnt      <= gap_cnt - idle_cnt_t'(1);
        end
    end

    a_r10_countdown: assert property (@(posedge clk) disable iff (rst)
        (gap_cnt != '0 && !take_write) |=> gap_cnt == $past(gap_cnt) - idle_cnt_t'(1));

    a_r10_ready_at_zero: assert property (@(posedge clk) disable iff (rst)
        gap_cnt == '0 |-> req_ready);

    a_r3_read_loads_nothing: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> gap_cnt == '0);

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        gap_cnt <= idle_cnt_t'(4));

endmodule

// File: rtl/turn_pin_oe.sv
module turn_pin_oe
    import turn_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         standby,
    input  standby_cfg_t sb_cfg,
    output logic         mem_pins_oe,
    output logic         clk_pins_oe
);

    assign mem_pins_oe = !standby || sb_cfg.drive_mem;
    assign clk_pins_oe = !standby || sb_cfg.drive_clk;

    a_r9_active_driven: assert property (@(posedge clk) disable iff (rst)
        !standby |-> (mem_pins_oe && clk_pins_oe));

    a_r8_groups_independent: assert property (@(posedge clk) disable iff (rst)
        (standby && sb_cfg.drive_mem != sb_cfg.drive_clk) |-> mem_pins_oe != clk_pins_oe);

endmodule

// File: rtl/bus_turnaround_gap.sv
module bus_turnaround_gap
    import turn_pkg::*;
#(
    parameter  int NUM_AREAS = 8,
    localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
    localparam int ADDR_W    = $clog2(NUM_AREAS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    output logic              req_ready,
    input  logic              standby,
    output logic              mem_pins_oe,
    output logic              clk_pins_oe
);

    idle_code_t   idle_codes [NUM_AREAS];
    standby_cfg_t sb_cfg;

    turn_cfg_regs #(
        .NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .idle_codes(idle_codes), .sb_cfg(sb_cfg)
    );

    turn_idle_ctrl #(
        .NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)
    ) u_idle (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
        .idle_codes(idle_codes), .req_ready(req_ready)
    );

    turn_pin_oe u_oe (
        .clk(clk), .rst(rst),
        .standby(standby), .sb_cfg(sb_cfg),
        .mem_pins_oe(mem_pins_oe), .clk_pins_oe(clk_pins_oe)
    );

endmodule

// File: tb/bus_turnaround_gap_test.sv
`timescale 1ns/1ps
module bus_turnaround_gap_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_area = '0;
    logic        req_ready;
    logic        standby = 1'b0;
    logic        mem_pins_oe;
    logic        clk_pins_oe;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    bus_turnaround_gap uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_area(req_area), .req_ready(req_ready),
        .standby(standby), .mem_pins_oe(mem_pins_oe), .clk_pins_oe(clk_pins_oe)
    );

    typedef struct packed {
        logic [2:0] code;
        logic [31:0] stall;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'b000, 32'd0}, '{3'b001, 32'd1}, '{3'b010, 32'd2}, '{3'b011, 32'd4},
        '{3'b100, 32'd4}, '{3'b101, 32'd4}, '{3'b110, 32'd4}, '{3'b111, 32'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic set_code(input logic [2:0] area, input logic [2:0] code);
        cfg_write({1'b0, area}, 32'(code) << 27);
    endtask

    // Accept a first access, then present a second one and count stall cycles.
    task automatic access_pair(input logic w1, input logic [2:0] a1,
                               input logic w2, input logic [2:0] a2,
                               output int stalls);
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_write = w1; req_area = a1;
        @(posedge clk);
        @(negedge clk);
        req_write = w2; req_area = a2;
        #1 stalls = 0;
        while (!req_ready) begin
            stalls++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int st;

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R5: reset values
        for (int a = 0; a < 8; a++) begin
            cfg_read(4'(a), rd);
            check("R5 area reset", rd, 32'h1800_0000);
        end
        cfg_read(4'd8, rd);
        check("R5 global reset", rd, 32'h0);
        @(negedge clk) standby = 1'b1;
        #1 check("R7 reset mem group floats", 32'(mem_pins_oe), 32'd0);
        check("R8 reset clk group floats", 32'(clk_pins_oe), 32'd0);
        @(negedge clk) standby = 1'b0;
        #1 check("R9 active both driven", {30'd0, mem_pins_oe, clk_pins_oe}, 32'd3);

        // R1/R2: table of codes, write followed by read on area 2
        for (int i = 0; i < 8; i++) begin
            set_code(3'd2, VECS[i].code);
            access_pair(1'b1, 3'd2, 1'b0, 3'd2, st);
            check(VECS[i].code[2] ? "R2 high code stall" : "R1 code stall", 32'(st), VECS[i].stall);
        end

        // R3: access after a read is not delayed
        set_code(3'd2, 3'b011);
        access_pair(1'b0, 3'd2, 1'b0, 3'd2, st);
        check("R3 read then read", 32'(st), 32'd0);
        access_pair(1'b0, 3'd2, 1'b1, 3'd2, st);
        check("R3 read then write", 32'(st), 32'd0);

        // R4: same-area write stalls, other-area write does not
        access_pair(1'b1, 3'd2, 1'b1, 3'd2, st);
        check("R4 write same area", 32'(st), 32'd4);
        set_code(3'd5, 3'b001);
        access_pair(1'b1, 3'd2, 1'b1, 3'd5, st);
        check("R4 write other area", 32'(st), 32'd0);

        // R10: last-written area governs the following read
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_area = 3'd2;
        @(posedge clk);
        @(negedge clk) req_area = 3'd5;
        @(posedge clk);
        @(negedge clk) req_write = 1'b0;
        #1 st = 0;
        while (!req_ready) begin st++; @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk) req_valid = 1'b0;
        check("R10 last written area sets gap", 32'(st), 32'd1);

        // R10: config write in the same cycle as the accepted bus write
        set_code(3'd3, 3'b011);
        repeat (6) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_area = 3'd3;
        cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 32'(3'b000) << 27;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; req_write = 1'b0;
        #1 st = 0;
        while (!req_ready) begin st++; @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk) req_valid = 1'b0;
        check("R10 same-cycle cfg keeps old gap", 32'(st), 32'd4);
        access_pair(1'b1, 3'd3, 1'b0, 3'd3, st);
        check("R10 new code used next write", 32'(st), 32'd0);

        // R6: reserved and unused bits
        cfg_write(4'd1, 32'hFFFF_FFFF);
        cfg_read(4'd1, rd);
        check("R6 reserved bits ignored", rd, 32'h3800_0000);

        // R11, R7, R8: global register and standby groups
        cfg_write(4'd8, 32'hFFFF_FFFE);
        cfg_read(4'd8, rd);
        check("R11 global only bits 1:0", rd, 32'h2);
        cfg_read(4'd9, rd);
        check("R11 unmapped reads zero", rd, 32'h0);
        @(negedge clk) standby = 1'b1;
        #1 check("R7 mem group driven", 32'(mem_pins_oe), 32'd1);
        check("R8 clk group floats", 32'(clk_pins_oe), 32'd0);
        cfg_write(4'd8, 32'h1);
        #1 check("R7 mem group floats", 32'(mem_pins_oe), 32'd0);
        check("R8 clk group driven", 32'(clk_pins_oe), 32'd1);
        @(negedge clk) standby = 1'b0;
        #1 check("R9 active overrides cfg", {30'd0, mem_pins_oe, clk_pins_oe}, 32'd3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule